// File: doc/BRIEF.md
# Serial Frame Master Engine (clock idle low, selectable phase)

This block is the transmitting and receiving core of a serial-port master. It takes words from a transmit queue over a valid/ready handshake and shifts each word out on a data line, most significant bit first. At the same time it collects the bits on the receive line into a right-aligned word, which it presents with a one-cycle strobe. It generates a serial clock that idles low. It drives an active-low frame select and active-low enables for the data-out pad and the clock pad.

The serial clock is derived from the system clock. Each half period lasts `half_div` system clocks. The phase input picks one of two modes. In phase 0 the data leads the first clock edge by half a period, and frame select pulses high between consecutive words. In phase 1 the data changes together with each rising edge, and frame select stays low across a stream of words. The word length runs from 4 to 16 bits. The length, the divider and the phase are captured when a word is accepted.

Top module: `spi_frame_master`

## Requirements
- R1: While no frame is in progress, `sclk` is 0, `fss_n` is 1, `txd` is 0 and `txd_oe_n` is 1.
- R2: `sclk_oe_n` is 0 when `master_mode` is 1 and 1 when `master_mode` is 0.
- R3: A word is accepted (`tx_ready` high in the same cycle as `tx_valid`) only when `enable` is 1. No frame starts while `enable` is 0. When a frame starts, `fss_n` and `txd_oe_n` fall together.
- R4: With `sph`=0, the MSB is on `txd` H system clocks after `fss_n` falls, and the first rising `sclk` edge comes 2H clocks after the fall. Bits are sampled on rising edges and changed on falling edges. H is the effective half period.
- R5: With `sph`=1, the first rising `sclk` edge comes H clocks after `fss_n` falls. Data changes on rising edges and is sampled on falling edges.
- R6: For the last word of a burst, `fss_n` returns to 1 exactly 2H clocks after the edge that samples its last bit. For a single word of N bits the frame therefore lasts (2N+2)·H clocks.
- R7: With `sph`=0, consecutive words each get their own frame, and `fss_n` is 1 for at least H clocks between them.
- R8: With `sph`=1 and a next word ready at the last sample, `fss_n` stays low and every `sclk` edge of the stream is exactly H clocks after the previous one.
- R9: `word_len` holds the word length minus one (3 to 15). Values below 3 act as 3. Only `tx_data[N-1:0]` is sent, starting with bit N-1.
- R10: `rx_data` holds the N sampled bits right-aligned, with the first sampled bit at position N-1. `rx_valid` is high for one cycle, starting at the clock edge that samples the last bit.
- R11: H equals `half_div`, and a `half_div` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Permits new words to be taken |
| master_mode | input | 1 | 1 drives the clock pad |
| sph | input | 1 | Clock phase select |
| word_len | input | 4 | Word length minus one |
| half_div | input | 8 | System clocks per serial half period |
| tx_valid | input | 1 | Transmit queue has a word |
| tx_ready | output | 1 | Word taken this cycle |
| tx_data | input | 16 | Word to send |
| rx_in | input | 1 | Serial receive line |
| sclk | output | 1 | Serial clock |
| fss_n | output | 1 | Frame select, active low |
| txd | output | 1 | Serial transmit line |
| txd_oe_n | output | 1 | Transmit pad enable, active low |
| sclk_oe_n | output | 1 | Clock pad enable, active low |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
The assertions assume that `tx_valid` and `tx_data` change only between clock edges and that `rx_in` is stable at the sampling edge. The bench's slave model drives `rx_in` on the falling system-clock edge following the serial edge on which the slave should shift, so it always has at least one system clock of setup. The configuration inputs are held constant while a burst is in flight. This matches the assertions' premise that the divider cannot shrink below the counter's current value.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int MAX_BITS = 16,
  parameter int DIV_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enable,
  input  logic                            master_mode,
  input  logic                            sph,
  input  logic [$clog2(MAX_BITS)-1:0]     word_len,
  input  logic [DIV_W-1:0]                half_div,
  input  logic                            tx_valid,
  output logic                            tx_ready,
  input  logic [MAX_BITS-1:0]             tx_data,
  input  logic                            rx_in,
  output logic                            sclk,
  output logic                            fss_n,
  output logic                            txd,
  output logic                            txd_oe_n,
  output logic                            sclk_oe_n,
  output logic [MAX_BITS-1:0]             rx_data,
  output logic                            rx_valid
);
  localparam int LEN_W = $clog2(MAX_BITS);
  localparam int HC_W  = $clog2(2 * MAX_BITS + 4);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(3);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_t;

  st_t                 st;
  logic [MAX_BITS-1:0] word_q, rx_q;
  logic [LEN_W-1:0]    len_q;
  logic                sph_q;
  logic [DIV_W-1:0]    div_q, dc;
  logic [HC_W-1:0]     hc;

  logic [LEN_W-1:0]    len_in, bit_no;
  logic [DIV_W-1:0]    div_in;
  logic [HC_W-1:0]     hc_n, last_hc;
  logic                tick, odd, load_idle, load_b2b;
  logic [MAX_BITS-1:0] rx_shift;

  assign len_in    = (word_len < MIN_LEN) ? MIN_LEN : word_len;
  assign div_in    = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick      = (st != S_IDLE) && (dc == div_q - DIV_W'(1));
  assign hc_n      = hc + HC_W'(1);
  assign odd       = hc_n[0];
  assign last_hc   = HC_W'({len_q, 1'b0}) + HC_W'(2);
  assign bit_no    = LEN_W'((hc_n - HC_W'(1)) >> 1);
  assign rx_shift  = {rx_q[MAX_BITS-2:0], rx_in};
  assign load_idle = (st == S_IDLE) && enable && tx_valid;
  assign load_b2b  = (st == S_RUN) && tick && sph_q && (hc_n == last_hc) && enable && tx_valid;
  assign tx_ready  = load_idle || load_b2b;

  assign fss_n     = (st != S_RUN);
  assign txd_oe_n  = (st != S_RUN);
  assign sclk_oe_n = ~master_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      word_q   <= '0;
      rx_q     <= '0;
      len_q    <= MIN_LEN;
      sph_q    <= 1'b0;
      div_q    <= DIV_W'(1);
      dc       <= '0;
      hc       <= '0;
      sclk     <= 1'b0;
      txd      <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (st == S_IDLE || tick) dc <= '0;
      else                      dc <= dc + DIV_W'(1);
      case (st)
        S_IDLE: if (load_idle) begin
          st     <= S_RUN;
          word_q <= tx_data;
          len_q  <= len_in;
          div_q  <= div_in;
          sph_q  <= sph;
          hc     <= '0;
          rx_q   <= '0;
        end
        S_RUN: if (tick) begin
          if (odd) begin
            if (hc_n < last_hc) txd <= word_q[len_q - bit_no];
            sclk <= sph_q && (hc_n < last_hc);
          end else if (hc_n <= last_hc) begin
            sclk <= ~sph_q;
            rx_q <= rx_shift;
          end
          if (hc_n == last_hc) begin
            rx_data  <= rx_shift;
            rx_valid <= 1'b1;
          end
          if (load_b2b) begin
            word_q <= tx_data;
            len_q  <= len_in;
            div_q  <= div_in;
            hc     <= '0;
            rx_q   <= '0;
          end else if (hc_n == last_hc + HC_W'(2)) begin
            st   <= S_TAIL;
            txd  <= 1'b0;
            sclk <= 1'b0;
          end else begin
            hc <= hc_n;
          end
        end
        S_TAIL: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!sclk && fss_n && !txd && txd_oe_n));

  // R3
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && enable));

  // R3
  start_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fss_n) |-> (!txd_oe_n && !sclk));

  // R6
  clock_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !fss_n);

  // R10
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R11
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) && (dc < div_q));
endmodule

// File: tb/spi_frame_master_tb.sv
`timescale 1ns/1ps
module spi_frame_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, master_mode = 1'b1, sph = 1'b0;
  logic [3:0] word_len = 4'd7;
  logic [7:0] half_div = 8'd1;
  logic tx_valid = 1'b0, tx_ready;
  logic [15:0] tx_data = '0;
  logic rx_in = 1'b0;
  logic sclk, fss_n, txd, txd_oe_n, sclk_oe_n, rx_valid;
  logic [15:0] rx_data;

  always #2.5 clk = ~clk;

  spi_frame_master u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
    .sph(sph), .word_len(word_len), .half_div(half_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_in(rx_in), .sclk(sclk), .fss_n(fss_n), .txd(txd),
    .txd_oe_n(txd_oe_n), .sclk_oe_n(sclk_oe_n),
    .rx_data(rx_data), .rx_valid(rx_valid));

  int total = 0, bad = 0;
  bit done = 0;

  // configuration seen by the slave model
  int nb = 8, hh = 1;
  logic [15:0] tx_words [4];
  logic [15:0] sl_words [5];
  logic [15:0] cap [4];
  logic [15:0] rx_got [4];
  int ncap, nrx, n_falls, bad_sp, sl_idx, bitcnt, ready_seen;
  int cyc = 0, t_fall, t_first_rise, t_fss_rise, t_last_edge, frame_len, min_gap;
  bit have_edge, seen_rise, oe_at_fall, txd_at_h;
  logic [15:0] mosi, sl_word;
  logic prev_sclk = 1'b0, prev_fss = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    ncap = 0; nrx = 0; n_falls = 0; bad_sp = 0; sl_idx = 0; bitcnt = 0;
    ready_seen = 0; have_edge = 0; seen_rise = 0; mosi = '0;
    min_gap = 1 << 20; frame_len = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (tx_ready) ready_seen++;
    if (rx_valid && nrx < 4) begin rx_got[nrx] = rx_data; nrx++; end
    if (prev_fss && !fss_n) begin
      if (n_falls > 0 && cyc - t_fss_rise < min_gap) min_gap = cyc - t_fss_rise;
      n_falls++; t_fall = cyc; seen_rise = 0; have_edge = 0; bitcnt = 0; mosi = '0;
      oe_at_fall = txd_oe_n;
      sl_word = sl_words[sl_idx];
      if (!sph) rx_in = sl_word[nb-1];
    end
    if (!prev_fss && fss_n) begin t_fss_rise = cyc; frame_len = cyc - t_fall; end
    if (!fss_n && cyc == t_fall + hh) txd_at_h = txd;
    if (sclk != prev_sclk) begin
      if (have_edge && cyc - t_last_edge != hh) bad_sp++;
      have_edge = 1; t_last_edge = cyc;
      if (sclk && !seen_rise) begin seen_rise = 1; t_first_rise = cyc; end
      if (sclk == !sph) begin
        mosi = {mosi[14:0], txd}; bitcnt++;
        if (bitcnt == nb) begin
          if (ncap < 4) cap[ncap] = mosi;
          ncap++; mosi = '0; bitcnt = 0;
          if (sl_idx < 4) sl_idx++;
          sl_word = sl_words[sl_idx];
        end
      end else if (bitcnt < nb) begin
        rx_in = sl_word[nb-1-bitcnt];
      end
    end
    prev_sclk = sclk; prev_fss = fss_n;
  end

  task automatic run_words(input bit ph, input int bits, input int wl, input int hd,
                           input int heff, input int nw);
    int idx = 0;
    sph = ph; nb = bits; hh = heff;
    word_len = 4'(wl); half_div = 8'(hd);
    clear_mon();
    enable = 1'b1; tx_valid = 1'b1; tx_data = tx_words[0];
    while (idx < nw) begin
      @(negedge clk);
      if (tx_ready) begin
        idx++;
        if (idx < nw) tx_data = tx_words[idx]; else tx_valid = 1'b0;
      end
    end
    repeat ((2 * bits + 6) * heff + 10) @(negedge clk);
  endtask

  task automatic check_data(input int nw, input int bits, input string req);
    logic [15:0] m = 16'((32'd1 << bits) - 1);
    chk(ncap == nw, req, ncap, nw);
    chk(nrx == nw, "R10", nrx, nw);
    for (int k = 0; k < nw && k < 4; k++) begin
      chk(cap[k] == (tx_words[k] & m), req, int'(cap[k]), int'(tx_words[k] & m));
      chk(rx_got[k] == (sl_words[k] & m), "R10", int'(rx_got[k]), int'(sl_words[k] & m));
    end
  endtask

  task automatic t_reset();
    chk(sclk == 1'b0 && fss_n == 1'b1, "R1", {sclk, fss_n}, 1);
    chk(txd == 1'b0 && txd_oe_n == 1'b1, "R1", {txd, txd_oe_n}, 1);
    chk(tx_ready == 1'b0 && rx_valid == 1'b0, "R1", {tx_ready, rx_valid}, 0);
    chk(sclk_oe_n == 1'b0, "R2", sclk_oe_n, 0);
  endtask

  task automatic t_ph0_single();
    tx_words[0] = 16'hF3A5; sl_words[0] = 16'h003C; sl_words[1] = 0;
    run_words(0, 8, 7, 2, 2, 1);
    chk(n_falls == 1, "R3", n_falls, 1);
    chk(oe_at_fall == 1'b0, "R3", oe_at_fall, 0);
    chk(txd_at_h == 1'b1, "R4", txd_at_h, 1);
    chk(t_first_rise - t_fall == 4, "R4", t_first_rise - t_fall, 4);
    chk(bad_sp == 0, "R4", bad_sp, 0);
    chk(frame_len == 18 * 2, "R6", frame_len, 36);
    check_data(1, 8, "R9");
    chk(fss_n && txd_oe_n && !txd && !sclk, "R1", {fss_n, txd_oe_n, txd, sclk}, 4'b1100);
  endtask

  task automatic t_ph1_single();
    tx_words[0] = 16'h0096; sl_words[0] = 16'h0069; sl_words[1] = 0;
    run_words(1, 8, 7, 3, 3, 1);
    chk(t_first_rise - t_fall == 3, "R5", t_first_rise - t_fall, 3);
    chk(bad_sp == 0, "R5", bad_sp, 0);
    chk(frame_len == 18 * 3, "R6", frame_len, 54);
    check_data(1, 8, "R5");
  endtask

  task automatic t_ph0_b2b();
    tx_words[0] = 16'h000A; tx_words[1] = 16'h0005; tx_words[2] = 16'h000C;
    sl_words[0] = 16'h0009; sl_words[1] = 16'h0006; sl_words[2] = 16'h0003; sl_words[3] = 0;
    run_words(0, 4, 3, 1, 1, 3);
    chk(n_falls == 3, "R7", n_falls, 3);
    chk(min_gap >= 1, "R7", min_gap, 1);
    check_data(3, 4, "R7");
  endtask

  task automatic t_ph1_b2b();
    tx_words[0] = 16'hBEEF; tx_words[1] = 16'h1234; tx_words[2] = 16'h8001;
    sl_words[0] = 16'hC0DE; sl_words[1] = 16'h7E81; sl_words[2] = 16'h0FF0; sl_words[3] = 0;
    run_words(1, 16, 15, 1, 1, 3);
    chk(n_falls == 1, "R8", n_falls, 1);
    chk(bad_sp == 0, "R8", bad_sp, 0);
    chk(frame_len == 2 * 16 * 3 + 2, "R8", frame_len, 98);
    check_data(3, 16, "R8");
  endtask

  task automatic t_short_len_zero_div();
    tx_words[0] = 16'hFFF6; sl_words[0] = 16'h000B; sl_words[1] = 0;
    run_words(0, 4, 1, 0, 1, 1);
    chk(t_first_rise - t_fall == 2, "R11", t_first_rise - t_fall, 2);
    chk(frame_len == 10, "R9", frame_len, 10);
    check_data(1, 4, "R9");
  endtask

  task automatic t_disabled();
    clear_mon();
    enable = 1'b0; tx_valid = 1'b1; tx_data = 16'h00AA;
    repeat (40) @(negedge clk);
    chk(n_falls == 0 && fss_n, "R3", n_falls, 0);
    chk(ready_seen == 0, "R3", ready_seen, 0);
    tx_valid = 1'b0; enable = 1'b1;
    master_mode = 1'b0;
    @(negedge clk);
    chk(sclk_oe_n == 1'b1, "R2", sclk_oe_n, 1);
    master_mode = 1'b1;
    @(negedge clk);
    chk(sclk_oe_n == 1'b0, "R2", sclk_oe_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ph0_single();
    t_ph1_single();
    t_ph0_b2b();
    t_ph1_b2b();
    t_short_len_zero_div();
    t_disabled();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule